// File: doc/BRIEF.md
# Interrupt presentation controller

This block sits beside one processor and decides which interrupt that processor sees. It keeps a single presented interrupt: a source number, the priority it came in at and the tag of the source unit that owns it. It drives one registered interrupt line from that state. Numerically smaller priorities win, and 0xFF means "none". A request from the source layer is either taken or refused. A taken request pushes out a weaker presented one, and the pushed-out source is sent back to its owner as a displacement notice so that it can be offered again later.

Software works on the unit through strobes. An accept strobe takes the presented interrupt. Other strobes write the processor's current priority and a software-set inter-processor-interrupt (IPI) priority, or signal end-of-interrupt. The IPI competes in the same arbitration as hardware sources, under a fixed source number with no owner. End-of-interrupt notices and a resend pulse go back to the source layer. The resend pulse asks the sources to offer again the requests they hold back.

Top module: `intr_presenter`

## Requirements
- R1: After reset, the presentation word reads 0, the IPI priority reads 0xFF, the interrupt line is low and no notice pulses. The pending priority starts at 0xFF.
- R2: Presentation word layout:
  - `pres_word[31:24]` is the current processor priority.
  - `pres_word[23:0]` is the presented source, where 0 means nothing is presented.
  - `irq_out` is high exactly when that source field is nonzero.
- R3: A request is refused when either of these holds: its priority is greater than or equal to the current priority, or something is presented with a pending priority less than or equal to the request's priority. A refused request gives a `nack` pulse one cycle later and leaves the state unchanged.
- R4: A taken request behaves as follows:
  - It becomes the presented source, with its owner and its priority as the pending priority, and the line goes high.
  - If the source it replaces had an owner, a `disp_valid` pulse carries the old source and owner one cycle later.
- R5: An accept strobe returns the word as it stands in that cycle. The word then becomes {pending priority, 24'h0}, the pending priority becomes 0xFF, the owner is dropped and the line goes low.
- R6: An IPI priority write behaves as follows:
  - The value is stored and shown on `ipi_prio`.
  - If the value is below the current priority and no presented interrupt has a pending priority less than or equal to it, source IPI_SRC (default 2) is presented with that pending priority and no owner.
  - An owned source that it replaces is reported as displaced.
- R7: A current-priority write stores the new value. If the value is lower than the old one, something is presented and the value is less than or equal to the pending priority, then the presented interrupt is withdrawn (source 0, line low, pending 0xFF). It is reported as displaced if it had an owner.
- R8: A resend is triggered by a current-priority write that is not lower than the old value while nothing is presented. The resend first offers the IPI if the IPI priority is below the current priority, then pulses `resend` one cycle later.
- R9: End-of-interrupt loads bits 31:24 of the written word as the current priority. It pulses `eoi_valid` with bits 23:0 one cycle later, and performs a resend (R8) if nothing is presented.
- R10: In a cycle with no strobe and no request, the presentation word, IPI priority and line do not change.
- R11: In one cycle, end-of-interrupt beats accept, and accept beats everything else. Otherwise the priority write is applied first, then the IPI write, then the request. A request arriving together with end-of-interrupt or accept is refused with `nack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Presentation request strobe |
| req_src | input | 24 | Requesting source number (nonzero) |
| req_prio | input | 8 | Request priority |
| req_owner | input | 4 | Tag of the source unit issuing the request |
| acc_rd | input | 1 | Accept strobe |
| cppr_we | input | 1 | Current-priority write strobe |
| cppr_wdata | input | 8 | Current-priority value |
| ipi_we | input | 1 | IPI-priority write strobe |
| ipi_wdata | input | 8 | IPI-priority value |
| eoi_we | input | 1 | End-of-interrupt strobe |
| eoi_wdata | input | 32 | End-of-interrupt word: priority in 31:24, source in 23:0 |
| pres_word | output | 32 | Presentation word (poll and accept read) |
| ipi_prio | output | 8 | Stored IPI priority |
| irq_out | output | 1 | Registered interrupt line to the processor |
| nack | output | 1 | Request refused |
| disp_valid | output | 1 | Displacement notice valid |
| disp_src | output | 24 | Displaced source number |
| disp_owner | output | 4 | Owner of the displaced source |
| eoi_valid | output | 1 | End-of-interrupt notice valid |
| eoi_src | output | 24 | Source named by the end-of-interrupt |
| resend | output | 1 | Resend request to the source layer |

## Verification
Most of the state is visible at the ports in the next cycle: a wrong presented source or current priority shows on `pres_word`, and a wrong line level shows on `irq_out`. The pending priority and the owner are hidden. A corrupted pending priority first surfaces when it decides a later request or IPI offer, or when an accept copies it into the priority field. A lost owner shows up as a missing displacement notice. The bench therefore follows directed sequences with a long random mix of strobes and requests, which drives the hidden state into those comparisons.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

   // Which operation group a cycle serves; order reflects precedence.
   typedef enum logic [1:0] {
      GRP_RUN = 2'd0,   // priority writes, IPI write, request (staged)
      GRP_ACC = 2'd1,   // accept read
      GRP_EOI = 2'd2    // end-of-interrupt
   } op_grp_e;

endpackage

// File: rtl/ipr_op_sel.sv
module ipr_op_sel (
   input  logic              eoi_we,
   input  logic              acc_rd,
   input  logic              req_valid,
   output ipr_pkg::op_grp_e  grp,
   output logic              req_defer
);
   import ipr_pkg::*;

   always_comb begin
      if (eoi_we)      grp = GRP_EOI;
      else if (acc_rd) grp = GRP_ACC;
      else             grp = GRP_RUN;
   end

   // a request that loses the cycle to eoi/accept is bounced (R11)
   assign req_defer = req_valid && (grp != GRP_RUN);

endmodule

// File: rtl/ipr_core.sv
module ipr_core #(
   parameter int PRIO_W  = 8,
   parameter int SRC_W   = 24,
   parameter int OWN_W   = 4,
   parameter int IPI_SRC = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  ipr_pkg::op_grp_e    grp,
   input  logic                req_valid,
   input  logic [SRC_W-1:0]    req_src,
   input  logic [PRIO_W-1:0]   req_prio,
   input  logic [OWN_W-1:0]    req_owner,
   input  logic                cppr_we,
   input  logic [PRIO_W-1:0]   cppr_wdata,
   input  logic                ipi_we,
   input  logic [PRIO_W-1:0]   ipi_wdata,
   input  logic [PRIO_W-1:0]   eoi_cppr,
   output logic [PRIO_W-1:0]   cppr_o,
   output logic [SRC_W-1:0]    src_o,
   output logic [PRIO_W-1:0]   pend_o,
   output logic [PRIO_W-1:0]   ipi_o,
   output logic [OWN_W-1:0]    own_o,
   output logic                ownv_o,
   output logic                irq_o,
   output logic                disp_ev,
   output logic                refuse_ev,
   output logic                resend_ev
);
   import ipr_pkg::*;

   localparam logic [PRIO_W-1:0] NONE     = '1;
   localparam logic [SRC_W-1:0]  IPI_CODE = SRC_W'(IPI_SRC);

   typedef struct packed {
      logic [PRIO_W-1:0] cppr;
      logic [SRC_W-1:0]  src;
      logic [PRIO_W-1:0] pend;
      logic [PRIO_W-1:0] ipi;
      logic [OWN_W-1:0]  own;
      logic              ownv;
      logic              irq;
   } st_t;

   st_t cur, nxt;

   // Offer the IPI into the arbitration; flags an owned source pushed out.
   function automatic st_t ipi_offer(input st_t a, output logic bumped);
      st_t b;
      b      = a;
      bumped = 1'b0;
      if (!((a.src != '0) && (a.pend <= a.ipi))) begin
         bumped = (a.src != '0) && a.ownv;
         b.src  = IPI_CODE;
         b.pend = a.ipi;
         b.ownv = 1'b0;
         b.irq  = 1'b1;
      end
      return b;
   endfunction

   st_t  t;
   logic dv, dtmp, refuse, rs;

   always_comb begin
      t      = cur;
      dv     = 1'b0;
      dtmp   = 1'b0;
      refuse = 1'b0;
      rs     = 1'b0;
      case (grp)
         GRP_EOI: begin
            t.cppr = eoi_cppr;
            if (t.src == '0) begin
               if (t.ipi < t.cppr) t = ipi_offer(t, dtmp);
               rs = 1'b1;
            end
         end
         GRP_ACC: begin
            t.cppr = cur.pend;
            t.src  = '0;
            t.pend = NONE;
            t.ownv = 1'b0;
            t.irq  = 1'b0;
         end
         default: begin
            // stage 1: current-priority write
            if (cppr_we) begin
               t.cppr = cppr_wdata;
               if (cppr_wdata < cur.cppr) begin
                  if ((t.src != '0) && (cppr_wdata <= t.pend)) begin
                     dv     = t.ownv;
                     t.src  = '0;
                     t.pend = NONE;
                     t.ownv = 1'b0;
                     t.irq  = 1'b0;
                  end
               end else if (t.src == '0) begin
                  if (t.ipi < t.cppr) begin
                     t  = ipi_offer(t, dtmp);
                     dv = dv | dtmp;
                  end
                  rs = 1'b1;
               end
            end
            // stage 2: IPI priority write
            if (ipi_we) begin
               t.ipi = ipi_wdata;
               if (t.ipi < t.cppr) begin
                  t  = ipi_offer(t, dtmp);
                  dv = dv | dtmp;
               end
            end
            // stage 3: incoming request
            if (req_valid) begin
               if ((req_prio >= t.cppr) || ((t.src != '0) && (t.pend <= req_prio))) begin
                  refuse = 1'b1;
               end else begin
                  dv     = dv | ((t.src != '0) && t.ownv);
                  t.src  = req_src;
                  t.own  = req_owner;
                  t.ownv = 1'b1;
                  t.pend = req_prio;
                  t.irq  = 1'b1;
               end
            end
         end
      endcase
      nxt = t;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur.cppr <= '0;
         cur.src  <= '0;
         cur.pend <= NONE;
         cur.ipi  <= NONE;
         cur.own  <= '0;
         cur.ownv <= 1'b0;
         cur.irq  <= 1'b0;
      end else begin
         cur <= nxt;
      end
   end

   assign cppr_o    = cur.cppr;
   assign src_o     = cur.src;
   assign pend_o    = cur.pend;
   assign ipi_o     = cur.ipi;
   assign own_o     = cur.own;
   assign ownv_o    = cur.ownv;
   assign irq_o     = cur.irq;
   assign disp_ev   = dv;
   assign refuse_ev = refuse;
   assign resend_ev = rs;

   // line register and source register are written by separate terms
   p_line_tracks_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cur.irq == (cur.src != '0));

   p_idle_pend_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cur.src == '0) |-> (cur.pend == NONE));

   p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (grp == GRP_RUN && !cppr_we && !ipi_we && !req_valid)
      |=> ($stable(cur.cppr) && $stable(cur.src) && $stable(cur.ipi)));

endmodule

// File: rtl/ipr_notice.sv
module ipr_notice #(
   parameter int SRC_W      = 24,
   parameter int OWN_W      = 4,
   parameter bit NOTICE_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              disp_ev,
   input  logic [SRC_W-1:0]  disp_src_in,
   input  logic [OWN_W-1:0]  disp_own_in,
   input  logic              nack_ev,
   input  logic              eoi_ev,
   input  logic [SRC_W-1:0]  eoi_src_in,
   input  logic              resend_ev,
   output logic              disp_valid,
   output logic [SRC_W-1:0]  disp_src,
   output logic [OWN_W-1:0]  disp_owner,
   output logic              nack,
   output logic              eoi_valid,
   output logic [SRC_W-1:0]  eoi_src,
   output logic              resend
);

   generate
      if (NOTICE_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               disp_valid <= 1'b0;
               disp_src   <= '0;
               disp_owner <= '0;
               nack       <= 1'b0;
               eoi_valid  <= 1'b0;
               eoi_src    <= '0;
               resend     <= 1'b0;
            end else begin
               disp_valid <= disp_ev;
               disp_src   <= disp_ev ? disp_src_in : '0;
               disp_owner <= disp_ev ? disp_own_in : '0;
               nack       <= nack_ev;
               eoi_valid  <= eoi_ev;
               eoi_src    <= eoi_ev ? eoi_src_in : '0;
               resend     <= resend_ev;
            end
         end
      end else begin : g_comb
         assign disp_valid = disp_ev;
         assign disp_src   = disp_ev ? disp_src_in : '0;
         assign disp_owner = disp_ev ? disp_own_in : '0;
         assign nack       = nack_ev;
         assign eoi_valid  = eoi_ev;
         assign eoi_src    = eoi_ev ? eoi_src_in : '0;
         assign resend     = resend_ev;
      end
   endgenerate

endmodule

// File: rtl/intr_presenter.sv
module intr_presenter #(
   parameter int PRIO_W     = 8,
   parameter int SRC_W      = 24,
   parameter int OWN_W      = 4,
   parameter int IPI_SRC    = 2,
   parameter bit NOTICE_REG = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [SRC_W-1:0]           req_src,
   input  logic [PRIO_W-1:0]          req_prio,
   input  logic [OWN_W-1:0]           req_owner,
   input  logic                       acc_rd,
   input  logic                       cppr_we,
   input  logic [PRIO_W-1:0]          cppr_wdata,
   input  logic                       ipi_we,
   input  logic [PRIO_W-1:0]          ipi_wdata,
   input  logic                       eoi_we,
   input  logic [PRIO_W+SRC_W-1:0]    eoi_wdata,
   output logic [PRIO_W+SRC_W-1:0]    pres_word,
   output logic [PRIO_W-1:0]          ipi_prio,
   output logic                       irq_out,
   output logic                       nack,
   output logic                       disp_valid,
   output logic [SRC_W-1:0]           disp_src,
   output logic [OWN_W-1:0]           disp_owner,
   output logic                       eoi_valid,
   output logic [SRC_W-1:0]           eoi_src,
   output logic                       resend
);
   import ipr_pkg::*;

   localparam int WORD_W = PRIO_W + SRC_W;

   initial begin
      assert (PRIO_W >= 2 && PRIO_W <= 16) else $error("PRIO_W out of range");
      assert (SRC_W >= 2 && SRC_W <= 30) else $error("SRC_W out of range");
      assert (OWN_W >= 1) else $error("OWN_W must be at least 1");
      assert (IPI_SRC > 0 && IPI_SRC < (1 << SRC_W)) else $error("IPI_SRC must be a nonzero source");
   end

   op_grp_e            grp;
   logic               req_defer;
   logic [PRIO_W-1:0]  cppr_q, pend_q;
   logic [SRC_W-1:0]   src_q;
   logic [OWN_W-1:0]   own_q;
   logic               ownv_q;
   logic               disp_ev, refuse_ev, resend_ev;

   ipr_op_sel u_sel (
      .eoi_we    (eoi_we),
      .acc_rd    (acc_rd),
      .req_valid (req_valid),
      .grp       (grp),
      .req_defer (req_defer)
   );

   ipr_core #(
      .PRIO_W  (PRIO_W),
      .SRC_W   (SRC_W),
      .OWN_W   (OWN_W),
      .IPI_SRC (IPI_SRC)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .grp        (grp),
      .req_valid  (req_valid),
      .req_src    (req_src),
      .req_prio   (req_prio),
      .req_owner  (req_owner),
      .cppr_we    (cppr_we),
      .cppr_wdata (cppr_wdata),
      .ipi_we     (ipi_we),
      .ipi_wdata  (ipi_wdata),
      .eoi_cppr   (eoi_wdata[WORD_W-1:SRC_W]),
      .cppr_o     (cppr_q),
      .src_o      (src_q),
      .pend_o     (pend_q),
      .ipi_o      (ipi_prio),
      .own_o      (own_q),
      .ownv_o     (ownv_q),
      .irq_o      (irq_out),
      .disp_ev    (disp_ev),
      .refuse_ev  (refuse_ev),
      .resend_ev  (resend_ev)
   );

   ipr_notice #(
      .SRC_W      (SRC_W),
      .OWN_W      (OWN_W),
      .NOTICE_REG (NOTICE_REG)
   ) u_notice (
      .clk         (clk),
      .rst_n       (rst_n),
      .disp_ev     (disp_ev),
      .disp_src_in (src_q),
      .disp_own_in (own_q),
      .nack_ev     (refuse_ev | req_defer),
      .eoi_ev      (grp == GRP_EOI),
      .eoi_src_in  (eoi_wdata[SRC_W-1:0]),
      .resend_ev   (resend_ev),
      .disp_valid  (disp_valid),
      .disp_src    (disp_src),
      .disp_owner  (disp_owner),
      .nack        (nack),
      .eoi_valid   (eoi_valid),
      .eoi_src     (eoi_src),
      .resend      (resend)
   );

   assign pres_word = {cppr_q, src_q};

   generate
      if (NOTICE_REG) begin : g_chk
         p_disp_names_prior_r4: assert property (@(posedge clk) disable iff (!rst_n)
            disp_valid |-> ($past(ownv_q) && disp_src == $past(src_q) && disp_owner == $past(own_q)));

         p_eoi_loads_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
            eoi_valid |-> (cppr_q == $past(eoi_wdata[WORD_W-1:SRC_W])
                           && eoi_src == $past(eoi_wdata[SRC_W-1:0])));

         p_nack_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
            nack |-> $past(req_valid));

         p_accept_drops_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(acc_rd) && !$past(eoi_we)) |-> (!irq_out && pend_q == '1));
      end
   endgenerate

endmodule

// File: tb/intr_presenter_test.sv
module intr_presenter_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int IPI = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 0;
   logic [23:0] req_src = '0;
   logic [7:0]  req_prio = '0;
   logic [3:0]  req_owner = '0;
   logic        acc_rd = 0, cppr_we = 0, ipi_we = 0, eoi_we = 0;
   logic [7:0]  cppr_wdata = '0, ipi_wdata = '0;
   logic [31:0] eoi_wdata = '0;
   logic [31:0] pres_word;
   logic [7:0]  ipi_prio;
   logic        irq_out, nack, disp_valid, eoi_valid, resend;
   logic [23:0] disp_src, eoi_src;
   logic [3:0]  disp_owner;

   intr_presenter uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
      .req_prio(req_prio), .req_owner(req_owner), .acc_rd(acc_rd),
      .cppr_we(cppr_we), .cppr_wdata(cppr_wdata), .ipi_we(ipi_we),
      .ipi_wdata(ipi_wdata), .eoi_we(eoi_we), .eoi_wdata(eoi_wdata),
      .pres_word(pres_word), .ipi_prio(ipi_prio), .irq_out(irq_out),
      .nack(nack), .disp_valid(disp_valid), .disp_src(disp_src),
      .disp_owner(disp_owner), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
      .resend(resend)
   );

   always #10 clk = ~clk;   // 50 MHz

   int total = 0;
   int bad = 0;
   bit done = 0;

   // behavioural reference state
   int m_cppr, m_src, m_pend, m_ipi, m_own, m_ownv, m_irq;
   int e_nack, e_disp, e_dsrc, e_down, e_eoi, e_esrc, e_rs;

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_cppr = 0; m_src = 0; m_pend = 255; m_ipi = 255; m_own = 0; m_ownv = 0; m_irq = 0;
      e_nack = 0; e_disp = 0; e_dsrc = 0; e_down = 0; e_eoi = 0; e_esrc = 0; e_rs = 0;
   endtask

   task automatic note_disp();
      e_disp = 1; e_dsrc = m_src; e_down = m_own;
   endtask

   task automatic m_offer();
      if (m_src != 0 && m_pend <= m_ipi) return;
      if (m_src != 0 && m_ownv != 0) note_disp();
      m_src = IPI; m_pend = m_ipi; m_ownv = 0; m_irq = 1;
   endtask

   task automatic m_resend();
      if (m_ipi < m_cppr) m_offer();
      e_rs = 1;
   endtask

   task automatic compare();
      chk(pres_word, (32'(m_cppr) << 24) | 32'(m_src), "R2 word");
      chk(32'(irq_out), 32'(m_irq), "R2 line");
      chk(32'(ipi_prio), 32'(m_ipi), "R6 ipi");
      chk(32'(nack), 32'(e_nack), "R3 nack");
      chk(32'(disp_valid), 32'(e_disp), "R4 disp");
      if (e_disp != 0) begin
         chk(32'(disp_src), 32'(e_dsrc), "R4 disp_src");
         chk(32'(disp_owner), 32'(e_down), "R4 disp_owner");
      end
      chk(32'(eoi_valid), 32'(e_eoi), "R9 eoi");
      if (e_eoi != 0) chk(32'(eoi_src), 32'(e_esrc), "R9 eoi_src");
      chk(32'(resend), 32'(e_rs), "R8 resend");
   endtask

   // drive one cycle of stimulus at a falling edge, advance the model, compare at next falling edge
   task automatic step(input bit e, input logic [31:0] ew, input bit a,
                       input bit cw, input logic [7:0] cv, input bit iw, input logic [7:0] iv,
                       input bit rv, input logic [23:0] rs, input logic [7:0] rp, input logic [3:0] ro);
      int old;
      eoi_we = e; eoi_wdata = ew; acc_rd = a; cppr_we = cw; cppr_wdata = cv;
      ipi_we = iw; ipi_wdata = iv; req_valid = rv; req_src = rs; req_prio = rp; req_owner = ro;
      e_nack = 0; e_disp = 0; e_eoi = 0; e_rs = 0;
      if (e) begin
         m_cppr = int'(ew[31:24]); e_eoi = 1; e_esrc = int'(ew[23:0]);
         if (m_src == 0) m_resend();
         if (rv) e_nack = 1;                        // R11 request loses to eoi
      end else if (a) begin
         m_cppr = m_pend; m_src = 0; m_pend = 255; m_ownv = 0; m_irq = 0;
         if (rv) e_nack = 1;                        // R11 request loses to accept
      end else begin
         if (cw) begin
            old = m_cppr; m_cppr = int'(cv);
            if (int'(cv) < old) begin
               if (m_src != 0 && int'(cv) <= m_pend) begin
                  if (m_ownv != 0) note_disp();
                  m_src = 0; m_pend = 255; m_ownv = 0; m_irq = 0;
               end
            end else if (m_src == 0) m_resend();
         end
         if (iw) begin
            m_ipi = int'(iv);
            if (m_ipi < m_cppr) m_offer();
         end
         if (rv) begin
            if (int'(rp) >= m_cppr || (m_src != 0 && m_pend <= int'(rp))) e_nack = 1;
            else begin
               if (m_src != 0 && m_ownv != 0) note_disp();
               m_src = int'(rs); m_own = int'(ro); m_ownv = 1; m_pend = int'(rp); m_irq = 1;
            end
         end
      end
      @(negedge clk);
      compare();
   endtask

   task automatic idle();
      step(0, '0, 0, 0, '0, 0, '0, 0, '0, '0, '0);
   endtask

   function automatic logic [7:0] pick_prio();
      case ($urandom_range(0, 9))
         0: return 8'h00;
         1: return 8'h01;
         2: return 8'h20;
         3: return 8'h40;
         4: return 8'h7F;
         5: return 8'h80;
         6: return 8'hC0;
         7: return 8'hFE;
         8: return 8'hFF;
         default: return 8'($urandom_range(0, 255));
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(pres_word, 32'h0000_0000, "R1 word");
      chk(32'(ipi_prio), 32'hFF, "R1 ipi");
      chk(32'(irq_out), 0, "R1 line");
      compare();

      // R3: current priority 0 refuses everything
      step(0, '0, 0, 0, '0, 0, '0, 1, 24'h5, 8'h03, 4'h1);
      chk(32'(nack), 1, "R3 refused at cppr 0");
      chk(pres_word, 32'h0, "R3 state kept");
      // R8: raise cppr with nothing presented -> resend, IPI 0xFF not offered
      step(0, '0, 0, 1, 8'hFF, 0, '0, 0, '0, '0, '0);
      chk(32'(resend), 1, "R8 resend");
      chk(pres_word, 32'hFF00_0000, "R8 no ipi");
      // R4: take a request
      step(0, '0, 0, 0, '0, 0, '0, 1, 24'h10, 8'h80, 4'h3);
      chk(pres_word, 32'hFF00_0010, "R4 presented");
      chk(32'(irq_out), 1, "R4 line");
      // R3: equal priority refused
      step(0, '0, 0, 0, '0, 0, '0, 1, 24'h11, 8'h80, 4'h4);
      chk(32'(nack), 1, "R3 equal pending");
      // R4: stronger request displaces owned one
      step(0, '0, 0, 0, '0, 0, '0, 1, 24'h12, 8'h40, 4'h5);
      chk(32'(disp_valid), 1, "R4 displaced");
      chk(32'(disp_src), 32'h10, "R4 displaced source");
      chk(32'(disp_owner), 32'h3, "R4 displaced owner");
      // R6: IPI blocked by stronger pending
      step(0, '0, 0, 0, '0, 1, 8'h60, 0, '0, '0, '0);
      chk(pres_word, 32'hFF00_0012, "R6 blocked");
      chk(32'(ipi_prio), 32'h60, "R6 stored");
      // R6: IPI wins
      step(0, '0, 0, 0, '0, 1, 8'h20, 0, '0, '0, '0);
      chk(pres_word, 32'hFF00_0002, "R6 ipi presented");
      chk(32'(disp_owner), 32'h5, "R6 displaced owner");
      // R5: accept returns current word then clears
      chk(pres_word, 32'hFF00_0002, "R5 read value");
      step(0, '0, 1, 0, '0, 0, '0, 0, '0, '0, '0);
      chk(pres_word, 32'h2000_0000, "R5 after accept");
      chk(32'(irq_out), 0, "R5 line low");
      // R9: eoi restores priority, resend re-offers IPI
      step(1, 32'hFF00_0002, 0, 0, '0, 0, '0, 0, '0, '0, '0);
      chk(32'(eoi_src), 32'h2, "R9 notice");
      chk(pres_word, 32'hFF00_0002, "R9 resend ipi");
      // R7: lowering cppr withdraws unowned IPI, no displacement notice
      step(0, '0, 0, 1, 8'h10, 0, '0, 0, '0, '0, '0);
      chk(pres_word, 32'h1000_0000, "R7 withdrawn");
      chk(32'(disp_valid), 0, "R7 unowned no notice");
      // R10: quiet cycle
      idle();
      chk(pres_word, 32'h1000_0000, "R10 hold");
      // R11: eoi beats a same-cycle request
      step(1, 32'hFF00_0000, 0, 0, '0, 0, '0, 1, 24'h30, 8'h01, 4'h2);
      chk(32'(nack), 1, "R11 request bounced");
      chk(pres_word, 32'hFF00_0002, "R11 eoi served");

      // random mix, compared against the model every cycle
      for (int i = 0; i < 4000; i++) begin
         bit e, a, cw, iw, rv;
         e  = ($urandom_range(0, 11) == 0);
         a  = ($urandom_range(0, 9) == 0);
         cw = ($urandom_range(0, 5) == 0);
         iw = ($urandom_range(0, 7) == 0);
         rv = ($urandom_range(0, 1) == 0);
         step(e, {pick_prio(), 24'($urandom_range(0, 40))}, a, cw, pick_prio(), iw, pick_prio(),
              rv, 24'($urandom_range(1, 40)), pick_prio(), 4'($urandom_range(0, 15)));
      end
      idle();

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule